// File: doc/BRIEF.md
# I2C Write-Only Dual Wiper Controller

This block is the digital front end of a two-channel tap selector. It listens on a two-wire I2C bus as a slave device and keeps two 8-bit wiper position codes. It samples SCL and SDA with a fast system clock, with no clocking from the bus itself. Both lines pass through a synchronizer and a glitch filter before START, STOP and clock edges are decoded.

A transfer carries three bytes: an address byte, a command byte and a data byte. The address byte holds a fixed four-bit prefix, three strap bits and an operation flag. The command byte chooses whether channel A, channel B or both take the data byte. The new code reaches the wiper outputs as soon as the data byte has been received. The block never drives read data. Its only bus output is a pull-down enable for an external open-drain SDA pad.

Top module: `wiper_i2c_ctrl`

## Requirements
- R1: After synchronous reset both wiper outputs read 0x80 (midscale) and the SDA pull-down is released.
- R2: An address byte whose upper seven bits are 0,1,0,1,strap_i[2],strap_i[1],strap_i[0] (MSB first) and whose eighth bit is 0 is acknowledged. The acknowledge holds SDA low for the whole SCL-high time of the ninth clock, and the pull-down only turns on while SCL is low.
- R3: An address byte that does not match gets no acknowledge. Every later byte until the next START is unacknowledged, and neither wiper changes.
- R4: A matching address whose eighth bit is 1 is acknowledged as a no-operation. The bytes that follow are not acknowledged and no wiper changes.
- R5: Command byte 0x11 loads the data byte into wiper A and leaves B unchanged. The new code appears on the output before SCL rises for the data byte's ninth clock.
- R6: Command byte 0x12 loads the data byte into wiper B and leaves A unchanged.
- R7: Command byte 0x13 loads the same data byte into both wipers in the same clock cycle.
- R8: Any other command byte is acknowledged, and so is the data byte after it, but neither wiper changes.
- R9: Bytes after the first data byte of a transfer are acknowledged and change nothing.
- R10: A START in any state, including a repeated START in the middle of a transfer, drops the transfer in progress and restarts address reception.
- R11: After a STOP the block is idle. Bytes clocked without a new START are neither acknowledged nor acted on.
- R12: A pulse on SCL or SDA shorter than GLITCH_CYC system clocks is ignored. It adds no bit and causes no false START or STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | SCL line level from the pad |
| sda_i | input | 1 | SDA line level from the pad |
| strap_i | input | 3 | Address strap bits, bit 2 is the most significant |
| sda_pull_o | output | 1 | 1 enables the open-drain pull-down on SDA |
| wiper_a_o | output | 8 | Wiper A position code, 0x00 nearest the low terminal |
| wiper_b_o | output | 8 | Wiper B position code, 0x00 nearest the low terminal |

## Verification
The bench builds the block with GLITCH_CYC = 4. This keeps the filter latency short, so each bus quarter-period can be 20 system clocks and a few dozen full transfers fit within the run. With this value a 2-cycle pulse sits below the threshold while the bus timing stays well above it. The bench can therefore inject sub-threshold pulses on SCL while it is low and on SDA while SCL is high, and confirm that neither an extra bit nor a false START or STOP results. The strap bits are changed between transfers, so both matching and non-matching addresses are exercised for more than one strap value.

// File: rtl/wiper_pkg.sv
// Package: shared constants, the transfer phase type and the command decode
// used by the wiper controller. Assumes 8-bit bus bytes and two channels.
package wiper_pkg;

    localparam int BYTE_W    = 8;
    localparam int NUM_WIPER = 2;
    localparam int STRAP_W   = 3;
    localparam logic [3:0] ADDR_PREFIX = 4'b0101;
    localparam logic [5:0] CMD_HEAD    = 6'b000100;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_CMD,
        PH_DATA,
        PH_EXTRA,
        PH_NOP
    } phase_e;

    // Returns one enable bit per channel; zero for an unrecognised command.
    function automatic logic [NUM_WIPER-1:0] cmd_mask(input logic [BYTE_W-1:0] cmd);
        logic [NUM_WIPER-1:0] m;
        m = '0;
        if (cmd[BYTE_W-1:2] == CMD_HEAD) begin
            m = cmd[1:0];
        end
        return m;
    endfunction

endpackage

// File: rtl/line_filter.sv
// Module: two-flop synchronizer followed by a persistence filter.
// The output follows the input only after the synchronized input has
// disagreed with it for GLITCH_CYC consecutive clocks. Assumes an idle-high line.
module line_filter #(
    parameter int GLITCH_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);
    localparam int CW = $clog2(GLITCH_CYC + 1);

    logic          sync1, sync2;
    logic [CW-1:0] cnt;

    // Bring the asynchronous line into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1 <= 1'b1;
            sync2 <= 1'b1;
        end else begin
            sync1 <= line_i;
            sync2 <= sync1;
        end
    end

    // Accept a new level only once it has persisted for GLITCH_CYC clocks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_o <= 1'b1;
            cnt    <= '0;
        end else if (sync2 == line_o) begin
            cnt <= '0;
        end else if (cnt == CW'(GLITCH_CYC - 1)) begin
            line_o <= sync2;
            cnt    <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/bus_events.sv
// Module: decodes START, STOP and SCL edges from the filtered lines.
// Events are single-cycle pulses, combinational from the filtered lines
// and their registered previous values.
module bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic start_o,
    output logic stop_o,
    output logic rise_o,
    output logic fall_o
);
    logic scl_q, sda_q;

    // Remember the previous filtered levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    // Classify each change relative to the SCL level.
    always_comb begin
        start_o = scl_q && scl_f && sda_q && !sda_f;
        stop_o  = scl_q && scl_f && !sda_q && sda_f;
        rise_o  = !scl_q && scl_f;
        fall_o  = scl_q && !scl_f;
    end
endmodule

// File: rtl/xfer_fsm.sv
// Module: byte receiver and transfer sequencer. It shifts bits on SCL rise,
// opens the acknowledge slot on the fall after the eighth bit, and closes it
// on the following fall. Write enables pulse for one cycle at slot opening.
module xfer_fsm
    import wiper_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic                 stop_i,
    input  logic                 rise_i,
    input  logic                 fall_i,
    input  logic                 sda_i,
    input  logic [STRAP_W-1:0]   strap_i,
    output logic                 pull_o,
    output logic [NUM_WIPER-1:0] wr_en_o,
    output logic [BYTE_W-1:0]    wr_data_o
);
    localparam int BCW = $clog2(BYTE_W + 1);
    localparam logic [BCW-1:0] LAST_BIT = BCW'(BYTE_W);

    phase_e               phase, next_phase;
    logic [BCW-1:0]       bitcnt;
    logic                 in_ack;
    logic [BYTE_W-1:0]    shreg;
    logic [BYTE_W-1:0]    cmd_q;
    logic                 ack_now;
    logic [NUM_WIPER-1:0] wr_now;
    logic                 addr_hit;

    // Decide the acknowledge, the next phase and any write for a finished byte.
    always_comb begin
        addr_hit   = (shreg[BYTE_W-1:1] == {ADDR_PREFIX, strap_i});
        ack_now    = 1'b0;
        next_phase = PH_IDLE;
        wr_now     = '0;
        unique case (phase)
            PH_ADDR: begin
                ack_now    = addr_hit;
                next_phase = !addr_hit ? PH_IDLE : (shreg[0] ? PH_NOP : PH_CMD);
            end
            PH_CMD: begin
                ack_now    = 1'b1;
                next_phase = PH_DATA;
            end
            PH_DATA: begin
                ack_now    = 1'b1;
                next_phase = PH_EXTRA;
                wr_now     = cmd_mask(cmd_q);
            end
            PH_EXTRA: begin
                ack_now    = 1'b1;
                next_phase = PH_EXTRA;
            end
            PH_NOP: begin
                next_phase = PH_NOP;
            end
            default: begin
                next_phase = PH_IDLE;
            end
        endcase
    end

    // Sequence bits, acknowledge slots and transfer phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_IDLE;
            bitcnt    <= '0;
            in_ack    <= 1'b0;
            shreg     <= '0;
            cmd_q     <= '0;
            pull_o    <= 1'b0;
            wr_en_o   <= '0;
            wr_data_o <= '0;
        end else begin
            wr_en_o <= '0;
            if (start_i) begin
                phase  <= PH_ADDR;
                bitcnt <= '0;
                in_ack <= 1'b0;
                pull_o <= 1'b0;
            end else if (stop_i) begin
                phase  <= PH_IDLE;
                bitcnt <= '0;
                in_ack <= 1'b0;
                pull_o <= 1'b0;
            end else if (phase != PH_IDLE) begin
                if (rise_i && !in_ack && bitcnt != LAST_BIT) begin
                    shreg  <= {shreg[BYTE_W-2:0], sda_i};
                    bitcnt <= bitcnt + 1'b1;
                end else if (fall_i && bitcnt == LAST_BIT) begin
                    if (!in_ack) begin
                        in_ack    <= 1'b1;
                        pull_o    <= ack_now;
                        phase     <= next_phase;
                        wr_en_o   <= wr_now;
                        wr_data_o <= shreg;
                        if (phase == PH_CMD) begin
                            cmd_q <= shreg;
                        end
                    end else begin
                        in_ack <= 1'b0;
                        pull_o <= 1'b0;
                        bitcnt <= '0;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/wiper_bank.sv
// Module: the wiper position registers, one per channel, reset to midscale.
// A channel loads the shared data byte when its enable bit is set.
module wiper_bank #(
    parameter int NUM = 2,
    parameter int W   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM-1:0]      wr_en_i,
    input  logic [W-1:0]        wr_data_i,
    output logic [NUM-1:0][W-1:0] wiper_o
);
    localparam logic [W-1:0] MIDSCALE = W'(1) << (W - 1);

    for (genvar g = 0; g < NUM; g++) begin : g_ch
        // Hold one channel's code; load on its enable.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                wiper_o[g] <= MIDSCALE;
            end else if (wr_en_i[g]) begin
                wiper_o[g] <= wr_data_i;
            end
        end
    end
endmodule

// File: rtl/wiper_i2c_ctrl.sv
// Module: top of the write-only two-channel wiper controller. It filters
// both bus lines, decodes bus events, runs the transfer sequencer and holds
// the wiper codes. Assumes clk runs at least about 20x the SCL rate plus filter time.
module wiper_i2c_ctrl
    import wiper_pkg::*;
#(
    parameter int GLITCH_CYC = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    input  logic [STRAP_W-1:0] strap_i,
    output logic               sda_pull_o,
    output logic [BYTE_W-1:0]  wiper_a_o,
    output logic [BYTE_W-1:0]  wiper_b_o
);
    logic [1:0] raw_lines, filt_lines;
    logic       scl_f, sda_f;
    logic       start_evt, stop_evt, scl_rise, scl_fall;
    logic [NUM_WIPER-1:0]             wr_en;
    logic [BYTE_W-1:0]                wr_data;
    logic [NUM_WIPER-1:0][BYTE_W-1:0] wipers;

    assign raw_lines = {sda_i, scl_i};

    for (genvar g = 0; g < 2; g++) begin : g_line
        line_filter #(.GLITCH_CYC(GLITCH_CYC)) u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .line_i (raw_lines[g]),
            .line_o (filt_lines[g])
        );
    end

    assign scl_f = filt_lines[0];
    assign sda_f = filt_lines[1];

    bus_events u_events (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_f   (scl_f),
        .sda_f   (sda_f),
        .start_o (start_evt),
        .stop_o  (stop_evt),
        .rise_o  (scl_rise),
        .fall_o  (scl_fall)
    );

    xfer_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_evt),
        .stop_i    (stop_evt),
        .rise_i    (scl_rise),
        .fall_i    (scl_fall),
        .sda_i     (sda_f),
        .strap_i   (strap_i),
        .pull_o    (sda_pull_o),
        .wr_en_o   (wr_en),
        .wr_data_o (wr_data)
    );

    wiper_bank #(.NUM(NUM_WIPER), .W(BYTE_W)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_data_i (wr_data),
        .wiper_o   (wipers)
    );

    assign wiper_a_o = wipers[0];
    assign wiper_b_o = wipers[1];
endmodule

// File: rtl/wiper_i2c_checker.sv
// Module: protocol and register properties for wiper_i2c_ctrl, attached by bind.
module wiper_i2c_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_f,
    input logic       fall,
    input logic       start,
    input logic       stop,
    input logic       sda_pull,
    input logic [7:0] wa,
    input logic [7:0] wb
);
    AST_RESET_MIDSCALE: assert property (@(posedge clk)
        $rose(rst_n) |-> (wa == 8'h80 && wb == 8'h80 && !sda_pull)); // R1

    AST_PULL_ON_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull) |-> !$past(scl_f)); // R2

    AST_WIPER_A_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (wa != $past(wa)) |-> $past(fall, 2)); // R5

    AST_WIPER_B_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (wb != $past(wb)) |-> $past(fall, 2)); // R6

    AST_BOTH_SAME_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        ((wa != $past(wa)) && (wb != $past(wb))) |-> (wa == wb)); // R7

    AST_START_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !sda_pull); // R10

    AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> !sda_pull); // R11
endmodule

bind wiper_i2c_ctrl wiper_i2c_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_f    (scl_f),
    .fall     (scl_fall),
    .start    (start_evt),
    .stop     (stop_evt),
    .sda_pull (sda_pull_o),
    .wa       (wiper_a_o),
    .wb       (wiper_b_o)
);

// File: tb/tb_wiper_i2c_ctrl.sv
// Bench: bus driver tasks push expected wiper pairs into a scoreboard queue;
// a monitor process pops them and compares against the outputs.
module tb_wiper_i2c_ctrl;
    localparam int Q  = 20;
    localparam int GC = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_drv = 1'b1;
    logic       sda_drv = 1'b1;
    logic [2:0] strap = 3'b101;
    logic       sda_pull;
    logic [7:0] wa, wb;
    logic       sda_line;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_a = 8'h80;
    logic [7:0] exp_b = 8'h80;
    bit done = 1'b0;

    typedef struct {
        logic [7:0] a;
        logic [7:0] b;
        string      req;
    } item_t;
    item_t sb[$];

    assign sda_line = sda_drv & ~sda_pull;

    always #4 clk = ~clk;

    wiper_i2c_ctrl #(.GLITCH_CYC(GC)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_drv),
        .sda_i      (sda_line),
        .strap_i    (strap),
        .sda_pull_o (sda_pull),
        .wiper_a_o  (wa),
        .wiper_b_o  (wb)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_now(input string req);
        item_t it;
        it.a = exp_a; it.b = exp_b; it.req = req;
        sb.push_back(it);
        wait (sb.size() == 0);
        wc(2);
    endtask

    task automatic bus_start();
        sda_drv = 1'b1; wc(Q);
        scl_drv = 1'b1; wc(Q);
        sda_drv = 1'b0; wc(Q);
        scl_drv = 1'b0; wc(Q);
    endtask

    task automatic bus_stop();
        sda_drv = 1'b0; wc(Q);
        scl_drv = 1'b1; wc(Q);
        sda_drv = 1'b1; wc(2 * Q);
    endtask

    // Send one byte MSB first and check the acknowledge; optional short pulses.
    task automatic send_byte(input logic [7:0] b, input bit exp_ack,
                             input string req, input bit glitch);
        logic s1, s2;
        for (int i = 7; i >= 0; i--) begin
            sda_drv = b[i]; wc(Q);
            scl_drv = 1'b1; wc(Q);
            if (glitch && b[i]) begin
                sda_drv = 1'b0; wc(GC - 2); sda_drv = 1'b1;
                wc(Q - GC + 2);
            end else begin
                wc(Q);
            end
            scl_drv = 1'b0;
            if (glitch && i == 5) begin
                wc(5); scl_drv = 1'b1; wc(GC - 2); scl_drv = 1'b0;
                wc(Q - 5 - GC + 2);
            end else begin
                wc(Q);
            end
        end
        sda_drv = 1'b1; wc(Q);
        scl_drv = 1'b1; wc(3);
        s1 = sda_line; wc(2 * Q - 5);
        s2 = sda_line; wc(2);
        scl_drv = 1'b0; wc(Q);
        chk((!s1 && !s2) == exp_ack, req, "ack", int'(!s1 && !s2), int'(exp_ack));
        if (exp_ack) chk(s1 == s2, "R2", "ack held through SCL high", int'(s2), int'(s1));
    endtask

    // Monitor: pop expected wiper pairs and compare with the outputs.
    initial begin
        item_t it;
        forever begin
            wait (sb.size() != 0);
            @(negedge clk);
            it = sb[0];
            chk(wa == it.a, it.req, "wiper A", int'(wa), int'(it.a));
            chk(wb == it.b, it.req, "wiper B", int'(wb), int'(it.b));
            void'(sb.pop_front());
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        wc(190000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        wc(4);
        rst_n = 1'b1;
        wc(4);
        // R1: reset state
        chk(sda_pull == 1'b0, "R1", "pull after reset", int'(sda_pull), 0);
        expect_now("R1");

        // R2, R5: write A with strap 101 -> address 0101101
        bus_start();
        send_byte({4'b0101, strap, 1'b0}, 1'b1, "R2", 1'b0);
        send_byte(8'h11, 1'b1, "R5", 1'b0);
        send_byte(8'h3A, 1'b1, "R5", 1'b0);
        exp_a = 8'h3A;
        chk(wa == 8'h3A, "R5", "A before stop", int'(wa), 8'h3A);
        bus_stop();
        expect_now("R5");

        // R6: write B
        bus_start();
        send_byte({4'b0101, strap, 1'b0}, 1'b1, "R6", 1'b0);
        send_byte(8'h12, 1'b1, "R6", 1'b0);
        send_byte(8'hFF, 1'b1, "R6", 1'b0);
        bus_stop();
        exp_b = 8'hFF;
        expect_now("R6");

        // R7: write both, other strap value
        strap = 3'b010;
        bus_start();
        send_byte({4'b0101, strap, 1'b0}, 1'b1, "R7", 1'b0);
        send_byte(8'h13, 1'b1, "R7", 1'b0);
        send_byte(8'h00, 1'b1, "R7", 1'b0);
        bus_stop();
        exp_a = 8'h00; exp_b = 8'h00;
        expect_now("R7");

        // R3: mismatched address (old strap) is ignored
        bus_start();
        send_byte({4'b0101, 3'b101, 1'b0}, 1'b0, "R3", 1'b0);
        send_byte(8'h11, 1'b0, "R3", 1'b0);
        send_byte(8'h55, 1'b0, "R3", 1'b0);
        bus_stop();
        expect_now("R3");
        bus_start();
        send_byte({4'b1101, strap, 1'b0}, 1'b0, "R3", 1'b0);
        send_byte(8'h13, 1'b0, "R3", 1'b0);
        send_byte(8'h66, 1'b0, "R3", 1'b0);
        bus_stop();
        expect_now("R3");

        // R4: no-operation flag
        bus_start();
        send_byte({4'b0101, strap, 1'b1}, 1'b1, "R4", 1'b0);
        send_byte(8'h13, 1'b0, "R4", 1'b0);
        send_byte(8'h77, 1'b0, "R4", 1'b0);
        bus_stop();
        expect_now("R4");

        // R8: unknown command
        bus_start();
        send_byte({4'b0101, strap, 1'b0}, 1'b1, "R8", 1'b0);
        send_byte(8'h14, 1'b1, "R8", 1'b0);
        send_byte(8'h99, 1'b1, "R8", 1'b0);
        bus_stop();
        expect_now("R8");
        bus_start();
        send_byte({4'b0101, strap, 1'b0}, 1'b1, "R8", 1'b0);
        send_byte(8'h91, 1'b1, "R8", 1'b0);
        send_byte(8'h98, 1'b1, "R8", 1'b0);
        bus_stop();
        expect_now("R8");

        // R9: extra bytes after data are acked and ignored
        bus_start();
        send_byte({4'b0101, strap, 1'b0}, 1'b1, "R9", 1'b0);
        send_byte(8'h11, 1'b1, "R9", 1'b0);
        send_byte(8'h42, 1'b1, "R9", 1'b0);
        send_byte(8'h12, 1'b1, "R9", 1'b0);
        send_byte(8'h24, 1'b1, "R9", 1'b0);
        bus_stop();
        exp_a = 8'h42;
        expect_now("R9");

        // R10: repeated START after command aborts the first transfer
        bus_start();
        send_byte({4'b0101, strap, 1'b0}, 1'b1, "R10", 1'b0);
        send_byte(8'h11, 1'b1, "R10", 1'b0);
        bus_start();
        send_byte({4'b0101, strap, 1'b0}, 1'b1, "R10", 1'b0);
        send_byte(8'h12, 1'b1, "R10", 1'b0);
        send_byte(8'h3C, 1'b1, "R10", 1'b0);
        bus_stop();
        exp_b = 8'h3C;
        expect_now("R10");

        // R11: after STOP, bytes without START are ignored
        bus_start();
        send_byte({4'b0101, strap, 1'b0}, 1'b1, "R11", 1'b0);
        send_byte(8'h13, 1'b1, "R11", 1'b0);
        bus_stop();
        scl_drv = 1'b0; wc(Q);
        send_byte(8'h5A, 1'b0, "R11", 1'b0);
        send_byte(8'hA5, 1'b0, "R11", 1'b0);
        bus_stop();
        expect_now("R11");

        // R12: short pulses on SCL and SDA are filtered out
        bus_start();
        send_byte({4'b0101, strap, 1'b0}, 1'b1, "R12", 1'b1);
        send_byte(8'h11, 1'b1, "R12", 1'b1);
        send_byte(8'hB7, 1'b1, "R12", 1'b1);
        bus_stop();
        exp_a = 8'hB7;
        expect_now("R12");

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule